// File: doc/BRIEF.md
# Load Wait Predictor

This block decides, for each load about to issue, whether it may go ahead speculatively or must hold until every older store has resolved its address. It keeps one wait bit per table entry, selected by low bits of the load's program counter just above the instruction alignment bits. With no history every load is treated as independent of earlier stores and issues at once. Memory dependences between particular loads and stores tend to repeat over time. So when the memory pipeline reports an ordering violation, meaning a load read memory before an older store to an overlapping address, the entry for that load is set. From then on, later instances of the same load are told to wait.

A violation also raises a one-cycle replay request carrying the offending PC. The recovery pipeline uses it to re-execute the load and its dependents; that replay is performed elsewhere. Predictions must not become permanent. The whole table is therefore wiped either by an explicit clear pulse or by an internal decay timer.

A two-state decay controller drives the wiping. It has the states DK_COUNT and DK_WIPE. In DK_COUNT a counter advances once per cycle. When the counter reaches its terminal value, or when a clear pulse is sampled, the controller moves to DK_WIPE (transition "expire" or "clear"). DK_WIPE lasts one cycle. During it lookups see an empty table, and at its end every entry is reset. The controller then returns to DK_COUNT with the counter at zero (transition "resume"). A clear pulse sampled while in DK_WIPE keeps it in DK_WIPE for one more cycle (transition "reclear").

Top module: `load_wait_predictor`

## Requirements
- R1: After reset every lookup returns wait = 0 and the replay request is low.
- R2: The entry used for a PC is the field pc[ALIGN_BITS +: log2(ENTRIES)]. The alignment bits below it and all bits above it play no part in selecting the entry.
- R3: A violation report sets the entry of its PC. Later lookups that map to that entry return wait = 1, and lookups that map to any other entry are unaffected.
- R4: A lookup made in the same cycle as a violation report to the same entry already returns wait = 1.
- R5: A violation reported in cycle n raises replay_req_o in cycle n+1 only, with replay_pc_o equal to the reported PC.
- R6: A clear pulse in cycle n causes every lookup from cycle n+1 on to return 0 until the table is relearned. This includes a bit set by a violation reported in cycle n itself.
- R7: A violation reported during the wipe cycle (cycle n+1 after a clear in cycle n) is retained in the table after the wipe.
- R8: After a clear in cycle n, the timer wipes the table again in cycle n+1+DECAY_CYCLES. An entry learned after the clear still returns 1 in cycle n+DECAY_CYCLES and returns 0 in cycle n+1+DECAY_CYCLES.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| lkp_pc_i | input | PC_W | PC of the load being looked up |
| lkp_wait_o | output | 1 | 1: hold the load until older store addresses resolve |
| viol_valid_i | input | 1 | Ordering violation reported this cycle |
| viol_pc_i | input | PC_W | PC of the violating load |
| clear_i | input | 1 | Wipe all learned entries |
| replay_req_o | output | 1 | One-cycle request to re-execute the violating load and dependents |
| replay_pc_o | output | PC_W | PC of the load to replay |

## Verification
The bench builds the block with 16 entries, a 16-bit PC, two alignment bits and a decay period of 64 cycles. The small table allows every entry to be trained in turn, with every other entry swept for false hits each time. Random upper and alignment bits in each PC exercise the aliasing rule. The short decay period places an exact cycle-by-cycle check of the timer wipe within a few dozen cycles of a clear.

// File: rtl/lwp_pkg.sv
package lwp_pkg;

    typedef enum logic [0:0] {
        DK_COUNT = 1'b0,
        DK_WIPE  = 1'b1
    } decay_state_e;

endpackage

// File: rtl/lwp_decay_ctrl.sv
module lwp_decay_ctrl
    import lwp_pkg::*;
#(
    parameter int DECAY_CYCLES = 16384
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear_i,
    output logic wipe_o
);
    localparam int CNT_W = (DECAY_CYCLES > 2) ? $clog2(DECAY_CYCLES) : 1;
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(DECAY_CYCLES - 2);

    decay_state_e state_q, state_d;
    logic [CNT_W-1:0] cnt_q;

    // next-state selection
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            DK_COUNT: if (clear_i || cnt_q == CNT_LAST) state_d = DK_WIPE;
            DK_WIPE:  if (!clear_i) state_d = DK_COUNT;
            default:  state_d = DK_COUNT;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= DK_COUNT;
        else        state_q <= state_d;
    end

    // decay counter: runs only while counting
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                  cnt_q <= '0;
        else if (state_q == DK_WIPE) cnt_q <= '0;
        else if (state_d == DK_COUNT) cnt_q <= cnt_q + 1'b1;
    end

    // outputs
    always_comb begin
        wipe_o = (state_q == DK_WIPE);
    end

    // R8
    cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CNT_LAST);

    // R8
    wipe_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == DK_WIPE && !clear_i) |=> (state_q == DK_COUNT));

    // R6
    clear_enter_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clear_i |=> (state_q == DK_WIPE));

endmodule

// File: rtl/lwp_wait_table.sv
module lwp_wait_table #(
    parameter int ENTRIES = 64,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wipe_i,
    input  logic             upd_en_i,
    input  logic [IDX_W-1:0] upd_idx_i,
    input  logic [IDX_W-1:0] rd_idx_i,
    output logic             rd_wait_o
);
    logic [ENTRIES-1:0] bits_q;

    for (genvar g = 0; g < ENTRIES; g++) begin : g_entry
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                                       bits_q[g] <= 1'b0;
            else if (upd_en_i && upd_idx_i == IDX_W'(g))      bits_q[g] <= 1'b1;
            else if (wipe_i)                                  bits_q[g] <= 1'b0;
        end
    end

    // stored bit is hidden during the wipe cycle; same-cycle update bypasses
    always_comb begin
        rd_wait_o = (bits_q[rd_idx_i] && !wipe_i)
                  || (upd_en_i && upd_idx_i == rd_idx_i);
    end

    // R3
    learn_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        upd_en_i |=> bits_q[$past(upd_idx_i)]);

    // R6
    wipe_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wipe_i && !upd_en_i) |=> (bits_q == '0));

    // R7
    wipe_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wipe_i && upd_en_i) |=> ($countones(bits_q) == 1));

endmodule

// File: rtl/lwp_replay_gen.sv
module lwp_replay_gen #(
    parameter int PC_W = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            viol_valid_i,
    input  logic [PC_W-1:0] viol_pc_i,
    output logic            replay_req_o,
    output logic [PC_W-1:0] replay_pc_o
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            replay_req_o <= 1'b0;
            replay_pc_o  <= '0;
        end else begin
            replay_req_o <= viol_valid_i;
            if (viol_valid_i) replay_pc_o <= viol_pc_i;
        end
    end

    // R5
    replay_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        viol_valid_i |=> (replay_req_o && replay_pc_o == $past(viol_pc_i)));

    // R5
    replay_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !viol_valid_i |=> !replay_req_o);

endmodule

// File: rtl/load_wait_predictor.sv
module load_wait_predictor #(
    parameter int PC_W         = 32,
    parameter int ENTRIES      = 64,
    parameter int ALIGN_BITS   = 2,
    parameter int DECAY_CYCLES = 16384
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [PC_W-1:0] lkp_pc_i,
    output logic            lkp_wait_o,
    input  logic            viol_valid_i,
    input  logic [PC_W-1:0] viol_pc_i,
    input  logic            clear_i,
    output logic            replay_req_o,
    output logic [PC_W-1:0] replay_pc_o
);
    localparam int IDX_W = $clog2(ENTRIES);

    logic             wipe;
    logic [IDX_W-1:0] lkp_idx;
    logic [IDX_W-1:0] viol_idx;

    assign lkp_idx  = lkp_pc_i[ALIGN_BITS +: IDX_W];
    assign viol_idx = viol_pc_i[ALIGN_BITS +: IDX_W];

    lwp_decay_ctrl #(
        .DECAY_CYCLES (DECAY_CYCLES)
    ) decay_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear_i (clear_i),
        .wipe_o  (wipe)
    );

    lwp_wait_table #(
        .ENTRIES (ENTRIES)
    ) table_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .wipe_i    (wipe),
        .upd_en_i  (viol_valid_i),
        .upd_idx_i (viol_idx),
        .rd_idx_i  (lkp_idx),
        .rd_wait_o (lkp_wait_o)
    );

    lwp_replay_gen #(
        .PC_W (PC_W)
    ) replay_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .viol_valid_i (viol_valid_i),
        .viol_pc_i    (viol_pc_i),
        .replay_req_o (replay_req_o),
        .replay_pc_o  (replay_pc_o)
    );

    // R4
    bypass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (viol_valid_i && viol_idx == lkp_idx) |-> lkp_wait_o);

endmodule

// File: tb/load_wait_predictor_tb_top.sv
module load_wait_predictor_tb_top;
    localparam int PC_W  = 16;
    localparam int ENT   = 16;
    localparam int ALIGN = 2;
    localparam int DECAY = 64;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [PC_W-1:0] lkp_pc = '0;
    logic            lkp_wait;
    logic            viol_valid = 1'b0;
    logic [PC_W-1:0] viol_pc = '0;
    logic            clear = 1'b0;
    logic            replay_req;
    logic [PC_W-1:0] replay_pc;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #5 clk = ~clk;

    load_wait_predictor #(
        .PC_W(PC_W), .ENTRIES(ENT), .ALIGN_BITS(ALIGN), .DECAY_CYCLES(DECAY)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .lkp_pc_i(lkp_pc), .lkp_wait_o(lkp_wait),
        .viol_valid_i(viol_valid), .viol_pc_i(viol_pc), .clear_i(clear),
        .replay_req_o(replay_req), .replay_pc_o(replay_pc)
    );

    function automatic logic [PC_W-1:0] pc_of(int idx, int salt);
        return {10'(salt * 37 + 5), 4'(idx), 2'(salt)};
    endfunction

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(logic [PC_W-1:0] got, logic [PC_W-1:0] exp, string req, string what);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s %s: got %0h expected %0h", req, what, got, exp);
        end
    endtask

    task automatic look(int idx, int salt, logic exp, string req);
        lkp_pc = pc_of(idx, salt);
        #1;
        chk(PC_W'(lkp_wait), PC_W'(exp), req, $sformatf("lookup idx %0d", idx));
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog: got hang expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) step();
        rst_n = 1'b1;
        step();
        // R1: reset state
        for (int j = 0; j < ENT; j++) look(j, j + 1, 1'b0, "R1");
        chk(PC_W'(replay_req), '0, "R1", "replay after reset");

        // R2 R3 R4 R5: train each entry in turn
        for (int i = 0; i < ENT; i++) begin
            clear = 1'b1; step();
            clear = 1'b0; step();
            step();
            viol_valid = 1'b1;
            viol_pc = pc_of(i, i);
            look(i, i + 3, 1'b1, "R4");
            step();
            viol_valid = 1'b0;
            chk(PC_W'(replay_req), 1, "R5", "replay pulse");
            chk(replay_pc, pc_of(i, i), "R5", "replay pc");
            for (int j = 0; j < ENT; j++) look(j, i + j + 7, (j == i), "R3");
            look(i, 200, 1'b1, "R2");
            step();
            chk(PC_W'(replay_req), 0, "R5", "replay one cycle");
        end

        // R6: clear discards earlier and same-cycle learning
        viol_valid = 1'b1; viol_pc = pc_of(5, 1); step();
        viol_valid = 1'b1; viol_pc = pc_of(7, 2); clear = 1'b1;
        look(7, 9, 1'b1, "R6");
        step();
        viol_valid = 1'b0; clear = 1'b0;
        look(5, 3, 1'b0, "R6");
        look(7, 3, 1'b0, "R6");
        step();
        look(5, 4, 1'b0, "R6");
        look(7, 4, 1'b0, "R6");

        // R7: learning during the wipe cycle survives
        clear = 1'b1; step();
        clear = 1'b0;
        viol_valid = 1'b1; viol_pc = pc_of(9, 6);
        look(9, 8, 1'b1, "R7");
        step();
        viol_valid = 1'b0;
        look(9, 11, 1'b1, "R7");
        look(8, 11, 1'b0, "R7");

        // R8: timed decay, clear in cycle n
        clear = 1'b1; step();          // n+1
        clear = 1'b0; step();          // n+2
        viol_valid = 1'b1; viol_pc = pc_of(3, 12); step(); // n+3
        viol_valid = 1'b0;
        for (int k = 0; k < DECAY - 3; k++) step();        // n+DECAY
        look(3, 13, 1'b1, "R8");
        step();                        // n+DECAY+1
        look(3, 14, 1'b0, "R8");
        step();
        look(3, 15, 1'b0, "R8");

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule